// File: doc/BRIEF.md
# Banked Data Memory with Bit Access and Stack

This block is the 128-byte internal data store of a small 8-bit controller core. The lowest 32 bytes double as four banks of eight working registers. Sixteen bytes above them can be set, cleared and read one bit at a time. The remaining bytes are free scratch space. An 8-bit stack pointer grows upward through the same storage.

The core reaches a byte through one of two paths. The first is a direct 8-bit address. The second is a register index R0..R7 combined with a two-bit bank select, which resolves onto the same bytes. Single bits are reached through a 7-bit bit address. Push and pop strobes move the stack pointer and move data to or from the byte it points at. All reads are combinational from the stored state. All writes take effect at the rising clock edge.

Top module: `dmem_core`

## Requirements
- R1: After the asynchronous reset, every byte 00H..7FH reads 00H and the stack pointer reads 07H.
- R2: With `byte_we_i` high and `reg_en_i` low, `byte_wdata_i` is stored at `byte_addr_i` on the clock edge. Every address 00H..7FH can be written and read back through `byte_rdata_o` with no added latency.
- R3: A byte address of 80H or above reads as 00H, and a write to it changes no stored byte.
- R4: With `reg_en_i` high, the byte port uses address {000b, `bank_sel_i`[1:0], `reg_idx_i`[2:0]} in place of `byte_addr_i`, for both reads and writes. For example, bank 0 R4 is the same byte as direct address 04H.
- R5: Bit address n (00H..7FH) selects bit n[2:0] of byte 20H + n[6:3]. `bit_rdata_o` returns that bit combinationally.
- R6: `bit_set_i` writes a 1 and `bit_clr_i` writes a 0 to the addressed bit in one cycle. The other seven bits of that byte are unchanged. If both strobes are high, the clear wins.
- R7: When several writes target the same byte in one cycle, the byte-port write wins over a push, and a push wins over a bit set or clear. Writes that target different bytes all take effect.
- R8: A push first increments the stack pointer and then stores `push_data_i` at the new pointer value. `pop_data_o` always shows the byte at the current pointer. A pop decrements the pointer at the edge.
- R9: The stack pointer wraps modulo 256. A push whose new pointer is 80H or above stores nothing, and `pop_data_o` reads 00H while the pointer is at 80H or above.
- R10: When `push_i` and `pop_i` are both high, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 2 | Working-register bank select |
| reg_en_i | input | 1 | Byte port uses the register index instead of the direct address |
| reg_idx_i | input | 3 | Register index R0..R7 |
| byte_addr_i | input | 8 | Direct byte address |
| byte_we_i | input | 1 | Byte write enable |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Byte read data |
| bit_addr_i | input | 7 | Bit address |
| bit_set_i | input | 1 | Set addressed bit |
| bit_clr_i | input | 1 | Clear addressed bit |
| bit_rdata_o | output | 1 | Addressed bit value |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 8 | Data to push |
| pop_data_o | output | 8 | Byte at the stack pointer |
| sp_o | output | 8 | Stack pointer |

## Verification
A byte-port write and a bit set or clear can land on the same byte in one cycle. So can a byte-port write and a push, or a push and a bit operation. The bench provokes each pair on purpose. For example, it writes byte 23H while setting a bit that lives in 23H. It also pushes onto a byte that the byte port writes in the same cycle. It then reads the byte back and compares it with the value that the stated priority predicts. It also pairs a byte write with a bit operation on a different byte, to show that both writes land.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef struct packed {
    logic  en;
    addr_t addr;
    byte_t data;
  } wr_req_t;

  typedef struct packed {
    logic     en;
    addr_t    addr;
    logic [2:0] pos;
    logic     val;
  } bit_req_t;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map
  import dmem_pkg::*;
#(
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned REG_W    = 3,
  parameter int unsigned BIT_AW   = 7,
  parameter int unsigned BIT_BASE = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              reg_en_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  addr_t             byte_addr_i,
  input  logic [BIT_AW-1:0] bit_addr_i,
  output addr_t             eff_addr_o,
  output addr_t             bit_byte_o,
  output logic [2:0]        bit_pos_o
);
  localparam int unsigned BIT_BYTES = 2 ** (BIT_AW - 3);

  assign eff_addr_o = reg_en_i ? addr_t'({bank_sel_i, reg_idx_i}) : byte_addr_i;
  assign bit_byte_o = addr_t'(BIT_BASE) + addr_t'(bit_addr_i[BIT_AW-1:3]);
  assign bit_pos_o  = bit_addr_i[2:0];

  // R4
  reg_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i |-> (int'(eff_addr_o) < 2 ** (BANK_W + REG_W)));
  // R5
  bit_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(bit_byte_o) >= BIT_BASE) && (int'(bit_byte_o) < BIT_BASE + BIT_BYTES));
endmodule

// File: rtl/dmem_stack.sv
module dmem_stack
  import dmem_pkg::*;
#(
  parameter int unsigned SP_RST = 7
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  logic    pop_i,
  input  byte_t   push_data_i,
  output addr_t   sp_o,
  output wr_req_t push_req_o
);
  addr_t sp_q, sp_d, sp_inc;

  assign sp_inc = sp_q + addr_t'(1);

  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_inc;
    else if (pop_i) sp_d = sp_q - addr_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= addr_t'(SP_RST);
    else         sp_q <= sp_d;
  end

  assign sp_o            = sp_q;
  assign push_req_o.en   = push_i;
  assign push_req_o.addr = sp_inc;
  assign push_req_o.data = push_data_i;

  // R8
  push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_o == addr_t'($past(sp_o) + addr_t'(1)));
  // R8
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_o == addr_t'($past(sp_o) - addr_t'(1)));
  // R9
  sp_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && sp_o == '1) |=> sp_o == '0);
  // R10
  sp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(sp_o));
endmodule

// File: rtl/dmem_array.sv
module dmem_array
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wr_req_t  byte_req_i,
  input  wr_req_t  push_req_i,
  input  bit_req_t bit_req_i,
  input  addr_t    byte_raddr_i,
  input  addr_t    pop_raddr_i,
  output byte_t    byte_rdata_o,
  output logic     bit_rdata_o,
  output byte_t    pop_rdata_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][DW-1:0] mem_q, nxt_d;
  logic [DEPTH-1:0]         we_d;

  function automatic logic in_range(addr_t a);
    return int'(a) < DEPTH;
  endfunction

  function automatic byte_t rd(logic [DEPTH-1:0][DW-1:0] m, addr_t a);
    return in_range(a) ? m[a[IDX_W-1:0]] : '0;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic hit_byte, hit_push, hit_bit;
    byte_t bit_val;
    assign hit_byte = byte_req_i.en && (int'(byte_req_i.addr) == i);
    assign hit_push = push_req_i.en && (int'(push_req_i.addr) == i);
    assign hit_bit  = bit_req_i.en  && (int'(bit_req_i.addr)  == i);
    always_comb begin
      bit_val = mem_q[i];
      bit_val[bit_req_i.pos] = bit_req_i.val;
    end
    // byte port > push > bit op
    assign nxt_d[i] = hit_byte ? byte_req_i.data :
                      hit_push ? push_req_i.data : bit_val;
    assign we_d[i]  = hit_byte | hit_push | hit_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (we_d[i]) mem_q[i] <= nxt_d[i];
    end
  end

  assign byte_rdata_o = rd(mem_q, byte_raddr_i);
  assign pop_rdata_o  = rd(mem_q, pop_raddr_i);
  assign bit_rdata_o  = rd(mem_q, bit_req_i.addr)[bit_req_i.pos];

  logic bit_solo;
  assign bit_solo = bit_req_i.en && in_range(bit_req_i.addr)
                 && !(byte_req_i.en && byte_req_i.addr == bit_req_i.addr)
                 && !(push_req_i.en && push_req_i.addr == bit_req_i.addr);

  // R2
  byte_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_i.en && in_range(byte_req_i.addr))
      |=> mem_q[$past(byte_req_i.addr[IDX_W-1:0])] == $past(byte_req_i.data));
  // R7
  push_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i.en && in_range(push_req_i.addr)
      && !(byte_req_i.en && byte_req_i.addr == push_req_i.addr))
      |=> mem_q[$past(push_req_i.addr[IDX_W-1:0])] == $past(push_req_i.data));
  // R6
  bit_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_solo |=> mem_q[$past(bit_req_i.addr[IDX_W-1:0])][$past(bit_req_i.pos)]
                 == $past(bit_req_i.val));
  // R6
  bit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_solo |=> ((mem_q[$past(bit_req_i.addr[IDX_W-1:0])] ^
                   $past(mem_q[bit_req_i.addr[IDX_W-1:0]]))
                  & ~(byte_t'(1) << $past(bit_req_i.pos))) == '0);
  // R3
  oob_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range(byte_raddr_i) |-> byte_rdata_o == '0);
endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned REG_W    = 3,
  parameter int unsigned BIT_AW   = 7,
  parameter int unsigned BIT_BASE = 32,
  parameter int unsigned SP_RST   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              reg_en_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [AW-1:0]     byte_addr_i,
  input  logic              byte_we_i,
  input  logic [DW-1:0]     byte_wdata_i,
  output logic [DW-1:0]     byte_rdata_o,
  input  logic [BIT_AW-1:0] bit_addr_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  output logic              bit_rdata_o,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DW-1:0]     push_data_i,
  output logic [DW-1:0]     pop_data_o,
  output logic [AW-1:0]     sp_o
);
  addr_t      eff_addr, bit_byte, sp;
  logic [2:0] bit_pos;
  wr_req_t    byte_req, push_req;
  bit_req_t   bit_req;

  dmem_addr_map #(
    .BANK_W(BANK_W), .REG_W(REG_W), .BIT_AW(BIT_AW), .BIT_BASE(BIT_BASE)
  ) u_map (
    .clk_i, .rst_ni, .bank_sel_i, .reg_en_i, .reg_idx_i, .byte_addr_i, .bit_addr_i,
    .eff_addr_o(eff_addr), .bit_byte_o(bit_byte), .bit_pos_o(bit_pos)
  );

  dmem_stack #(.SP_RST(SP_RST)) u_stack (
    .clk_i, .rst_ni, .push_i, .pop_i, .push_data_i,
    .sp_o(sp), .push_req_o(push_req)
  );

  assign byte_req = '{en: byte_we_i, addr: eff_addr, data: byte_wdata_i};
  // clear wins over set
  assign bit_req  = '{en: bit_set_i | bit_clr_i, addr: bit_byte, pos: bit_pos,
                      val: bit_set_i & ~bit_clr_i};

  dmem_array #(.DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni,
    .byte_req_i(byte_req), .push_req_i(push_req), .bit_req_i(bit_req),
    .byte_raddr_i(eff_addr), .pop_raddr_i(sp),
    .byte_rdata_o, .bit_rdata_o, .pop_rdata_o(pop_data_o)
  );

  assign sp_o = sp;
endmodule

// File: tb/dmem_core_tb.sv
module dmem_core_tb_top;
  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic [1:0] bank = 0;
  logic       reg_en = 0, we = 0, bs = 0, bc = 0, ps = 0, pp = 0;
  logic [2:0] ridx = 0;
  logic [7:0] addr = 0, wd = 0, pd = 0, rdata, popd, sp;
  logic [6:0] baddr = 0;
  logic       brd;

  dmem_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bank_sel_i(bank), .reg_en_i(reg_en), .reg_idx_i(ridx),
    .byte_addr_i(addr), .byte_we_i(we), .byte_wdata_i(wd), .byte_rdata_o(rdata),
    .bit_addr_i(baddr), .bit_set_i(bs), .bit_clr_i(bc), .bit_rdata_o(brd),
    .push_i(ps), .pop_i(pp), .push_data_i(pd), .pop_data_o(popd), .sp_o(sp)
  );

  int total = 0, fails = 0;
  logic [7:0] m [128];
  logic [7:0] msp;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(logic [7:0] a);
    return a < 8'h80 ? m[a[6:0]] : 8'h00;
  endfunction

  // one clock with the current drive values; model updated by stated priority
  task automatic tick();
    logic [7:0] eff, bb, pa;
    #1;
    if (pp && !ps) chk("R8 pop data", popd, mrd(msp));
    eff = reg_en ? {3'b000, bank, ridx} : addr;
    bb  = 8'h20 + {4'h0, baddr[6:3]};
    pa  = msp + 8'd1;
    if (bs || bc) m[bb[6:0]][baddr[2:0]] = bc ? 1'b0 : 1'b1;
    if (ps && pa < 8'h80) m[pa[6:0]] = pd;
    if (we && eff < 8'h80) m[eff[6:0]] = wd;
    if (ps) msp = pa; else if (pp) msp = msp - 8'd1;
    @(posedge clk); #1;
    we = 0; bs = 0; bc = 0; ps = 0; pp = 0; reg_en = 0;
  endtask

  task automatic sweep_bytes(string req);
    for (int i = 0; i < 128; i++) begin
      addr = 8'(i); #0.5;
      chk(req, rdata, m[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m[i] = 0;
    msp = 8'h07;
    #7 rst_ni = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 sp", sp, 8'h07);
    sweep_bytes("R1 zero");

    // R2 fill every byte directly
    for (int i = 0; i < 128; i++) begin
      addr = 8'(i); wd = 8'((i * 37 + 5) & 255); we = 1; tick();
    end
    sweep_bytes("R2 readback");

    // R3 writes above 7FH ignored, reads zero
    foreach (m[k]) ;
    for (int a = 128; a < 256; a += 19) begin
      addr = 8'(a); wd = 8'hA5; we = 1; tick();
      #0.5 chk("R3 oob read", rdata, 0);
    end
    sweep_bytes("R3 no alias");

    // R4 register aliasing in every bank
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++) begin
        bank = 2'(b); ridx = 3'(r); reg_en = 1; #0.5;
        chk("R4 reg read", rdata, m[b * 8 + r]);
        reg_en = 1; wd = 8'(b * 16 + r + 8'h40); we = 1; tick();
        addr = 8'(b * 8 + r); #0.5;
        chk("R4 direct alias", rdata, 8'(b * 16 + r + 8'h40));
      end

    // R5 bit reads across the whole bit region
    for (int n = 0; n < 128; n++) begin
      baddr = 7'(n); #0.5;
      chk("R5 bit read", brd, m[32 + n / 8][n % 8]);
    end

    // R6 set, clear, both; neighbours untouched
    for (int n = 0; n < 128; n += 5) begin
      baddr = 7'(n); bs = 1; tick();
      addr = 8'(32 + n / 8); #0.5 chk("R6 set", rdata, m[32 + n / 8]);
      chk("R6 set bit", brd, 1);
      baddr = 7'(n); bc = 1; tick();
      #0.5 chk("R6 clear", rdata, m[32 + n / 8]);
      baddr = 7'(n); bs = 1; tick();
      baddr = 7'(n); bs = 1; bc = 1; tick();
      #0.5 chk("R6 both clears", brd, 0);
    end

    // R7 byte write vs bit op on same byte (23H holds bits 18H..1FH)
    addr = 8'h23; wd = 8'h00; we = 1; baddr = 7'h1C; bs = 1; tick();
    addr = 8'h23; #0.5 chk("R7 byte over bit", rdata, 8'h00);
    // different bytes: both land
    addr = 8'h40; wd = 8'h77; we = 1; baddr = 7'h01; bs = 1; tick();
    addr = 8'h40; #0.5 chk("R7 both byte", rdata, 8'h77);
    addr = 8'h20; #0.5 chk("R7 both bit", rdata, m[32]);

    // R8 push/pop from reset pointer
    for (int i = 0; i < 6; i++) begin pd = 8'(8'hC0 + i); ps = 1; tick(); end
    chk("R8 sp after push", sp, 8'h0D);
    addr = 8'h0D; #0.5 chk("R8 top", rdata, 8'hC5);
    for (int i = 0; i < 3; i++) begin pp = 1; tick(); end
    chk("R8 sp after pop", sp, 8'h0A);

    // R10 push and pop together
    pd = 8'h5A; ps = 1; pp = 1; tick();
    chk("R10 sp", sp, 8'h0B);
    #0.5 chk("R10 data", popd, 8'h5A);

    // R7 push vs byte write same byte; push vs bit op
    pd = 8'h11; ps = 1; addr = 8'h0C; wd = 8'h99; we = 1; tick();
    addr = 8'h0C; #0.5 chk("R7 byte over push", rdata, 8'h99);
    // R9 wrap: climb to FFH; pushes above 7FH store nothing
    while (sp != 8'h1F) begin pd = sp; ps = 1; tick(); end
    pd = 8'hEE; ps = 1; baddr = 7'h00; bs = 1; tick();
    addr = 8'h20; #0.5 chk("R7 push over bit", rdata, 8'hEE);
    while (sp != 8'hFF) begin pd = 8'h3C; ps = 1; tick(); end
    sweep_bytes("R9 no store above 7FH");
    #0.5 chk("R9 pop data oob", popd, 0);
    pd = 8'hB4; ps = 1; tick();
    chk("R9 sp wrap", sp, 8'h00);
    addr = 8'h00; #0.5 chk("R9 wrap store", rdata, 8'hB4);
    pp = 1; tick();
    chk("R9 sp unwrap", sp, 8'hFF);
    pp = 1; tick();
    chk("R9 sp", sp, 8'hFE);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule